// File: doc/BRIEF.md
# LIN Frame Checksum Unit

This block produces and verifies the one-byte checksum that closes a LIN frame. A start pulse opens a frame: it takes the protected identifier, the number of data bytes (1 to 8), and the configuration that applies to the frame. Data bytes then arrive one per valid strobe and are folded into an 8-bit running sum. Each carry out of bit 7 is added back into bit 0. After the last data byte the block presents the inverted sum as the checksum to transmit.

When the block receives a frame, the byte that follows the data bytes is the checksum from the remote node. The block adds this byte to the running sum and flags an error for one cycle if the result is not 0xFF. A protocol-select input chooses between two checksums. The enhanced checksum includes the identifier in the sum. The classic checksum covers the data bytes only. One LIN configuration value removes the checksum field entirely. In UART operation the block produces and checks no checksum.

Top module: `lin_cksum_unit`

## Requirements
- R1: When `classic_i` is 0 at the start pulse, the sum starts from `pid_i`. After the last data byte, `cksum_o` equals the bitwise inverse of the sum of the identifier and all data bytes.
- R2: When `classic_i` is 1 at the start pulse, the identifier is left out of the sum. After the last data byte, `cksum_o` equals the inverse of the sum of the data bytes only.
- R3: When `uart_i` is 1 at the start pulse, the block ignores `classic_i`. `cksum_o` stays 0x00, `cksum_rdy_o` stays 0 and `cksum_err_o` stays 0 for that frame.
- R4: When `lin_cfg_i` is 2'b01 at the start pulse, the frame has no checksum field. The outputs behave as in R3. The values 2'b00, 2'b10 and 2'b11 give a normal checksum.
- R5: The sum is an 8-bit addition in which the carry out of bit 7 is added back into bit 0.
- R6: While `cksum_rdy_o` is 1, a byte with `data_vld_i` is the received checksum. `cksum_err_o` is 1 in the cycle after that byte if the byte plus the sum (same addition as R5) is not 0xFF, and is 0 otherwise. The flag lasts exactly one cycle.
- R7: `len_i` is sampled at the start pulse. A value of 0 counts as 1 and any value above 8 counts as 8. `cksum_rdy_o` and a valid `cksum_o` appear in the cycle after the last data byte.
- R8: A start pulse clears the sum and opens a new frame. If a start pulse and a checksum byte fall in the same cycle, the byte is judged against the old frame and is not added into the new frame.
- R9: Bytes strobed after the frame has finished, or before the first start pulse, are ignored. `cksum_o` is unchanged and no error is raised.
- R10: After reset, `cksum_o` is 0x00, and `cksum_rdy_o` and `cksum_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start pulse |
| pid_i | input | 8 | Protected identifier, sampled at start |
| len_i | input | 4 | Data byte count, sampled at start |
| classic_i | input | 1 | 1 selects the classic checksum, 0 the enhanced checksum |
| lin_cfg_i | input | 2 | LIN configuration; 2'b01 removes the checksum field |
| uart_i | input | 1 | UART operation, no checksum |
| data_i | input | 8 | Data or received checksum byte |
| data_vld_i | input | 1 | Byte strobe |
| cksum_o | output | 8 | Checksum to transmit |
| cksum_rdy_o | output | 1 | Checksum field is due |
| cksum_err_o | output | 1 | Received checksum mismatch, one-cycle pulse |

## Verification
The start of a new frame and the judging of the previous frame's checksum byte can fall in the same cycle. The bench provokes this by raising `start_i` in the cycle that carries the closing byte, once with a correct byte and once with a wrong one. It then checks two things: the error flag reflects the old frame, and the checksum of the new frame is computed without that byte. Sweeps over every length code, protocol select, configuration value and UART setting are compared against a sum that the bench builds as an integer total with the carries folded back in afterwards.

// File: rtl/lin_ck_pkg.sv
package lin_ck_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_CKSUM, PH_DONE} lin_ph_e;

  // 8-bit add with end-around carry
  function automatic logic [BYTE_W-1:0] addc(input logic [BYTE_W-1:0] a,
                                             input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
  endfunction

  // length code to effective byte count
  function automatic int clamp_len(input int code, input int max_len);
    if (code == 0) return 1;
    if (code > max_len) return max_len;
    return code;
  endfunction
endpackage

// File: rtl/lin_ck_seq.sv
module lin_ck_seq
  import lin_ck_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       lin_cfg_i,
  input  logic             uart_i,
  output logic             data_ev,
  output logic             chk_ev,
  output lin_ph_e          phase_q,
  output logic             supp_q
);
  localparam int CW = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt_q, len_q, cnt_nx;
  logic          supp_nx;

  assign supp_nx = uart_i || (lin_cfg_i == 2'b01);
  assign cnt_nx  = cnt_q + 1'b1;
  assign data_ev = vld_i && !start_i && (phase_q == PH_DATA);
  assign chk_ev  = vld_i && (phase_q == PH_CKSUM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= CW'(1);
      supp_q  <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      len_q   <= CW'(clamp_len(int'(len_i), MAX_LEN));
      supp_q  <= supp_nx;
    end else if (data_ev) begin
      cnt_q <= cnt_nx;
      if (cnt_nx == len_q) phase_q <= supp_q ? PH_DONE : PH_CKSUM;
    end else if (chk_ev) begin
      phase_q <= PH_DONE;
    end
  end
endmodule

// File: rtl/lin_ck_acc.sv
module lin_ck_acc
  import lin_ck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              classic_i,
  input  logic [BYTE_W-1:0] pid_i,
  input  logic              data_ev,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (start_i)  acc_q <= classic_i ? '0 : pid_i;
    else if (data_ev)  acc_q <= addc(acc_q, data_i);
  end
endmodule

// File: rtl/lin_ck_judge.sv
module lin_ck_judge
  import lin_ck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_ev,
  input  logic [BYTE_W-1:0] acc_q,
  input  logic [BYTE_W-1:0] data_i,
  output logic              err_q
);
  logic bad;
  assign bad = (addc(acc_q, data_i) != {BYTE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= chk_ev && bad;
  end
endmodule

// File: rtl/lin_cksum_unit.sv
module lin_cksum_unit
  import lin_ck_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       pid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             classic_i,
  input  logic [1:0]       lin_cfg_i,
  input  logic             uart_i,
  input  logic [7:0]       data_i,
  input  logic             data_vld_i,
  output logic [7:0]       cksum_o,
  output logic             cksum_rdy_o,
  output logic             cksum_err_o
);
  logic       data_ev, chk_ev, supp_q;
  lin_ph_e    phase_q;
  logic [7:0] acc_q;

  lin_ck_seq #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) i_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vld_i(data_vld_i),
    .len_i(len_i), .lin_cfg_i(lin_cfg_i), .uart_i(uart_i),
    .data_ev(data_ev), .chk_ev(chk_ev), .phase_q(phase_q), .supp_q(supp_q)
  );

  lin_ck_acc i_acc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .classic_i(classic_i),
    .pid_i(pid_i), .data_ev(data_ev), .data_i(data_i), .acc_q(acc_q)
  );

  lin_ck_judge i_judge (
    .clk(clk), .rst_n(rst_n), .chk_ev(chk_ev), .acc_q(acc_q),
    .data_i(data_i), .err_q(cksum_err_o)
  );

  assign cksum_rdy_o = (phase_q == PH_CKSUM);
  assign cksum_o     = ((phase_q == PH_CKSUM || phase_q == PH_DONE) && !supp_q)
                       ? ~acc_q : 8'h00;
endmodule

// File: rtl/lin_cksum_chk.sv
module lin_cksum_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       classic_i,
  input logic [7:0] pid_i,
  input logic [7:0] data_i,
  input logic       data_ev,
  input logic       chk_ev,
  input logic       supp_q,
  input logic [7:0] acc_q,
  input logic       cksum_rdy_o,
  input logic       cksum_err_o
);
  p_init_enh_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !classic_i |=> acc_q == $past(pid_i));

  p_init_cls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && classic_i |=> acc_q == 8'h00);

  // R3 and R4: a suppressed frame never offers or judges a checksum
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    supp_q |-> !cksum_rdy_o && !chk_ev);

  p_addc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ev |=> acc_q == lin_ck_pkg::addc($past(acc_q), $past(data_i)));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err_o |-> $past(chk_ev));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err_o |=> !cksum_err_o);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_ev, chk_ev}));
endmodule

bind lin_cksum_unit lin_cksum_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .classic_i(classic_i),
  .pid_i(pid_i), .data_i(data_i), .data_ev(data_ev), .chk_ev(chk_ev),
  .supp_q(supp_q), .acc_q(acc_q), .cksum_rdy_o(cksum_rdy_o),
  .cksum_err_o(cksum_err_o)
);

// File: tb/test_lin_cksum_unit.sv
`timescale 1ns/1ps
module test_lin_cksum_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] pid_i = 8'h00;
  logic [3:0] len_i = 4'd0;
  logic       classic_i = 1'b0;
  logic [1:0] lin_cfg_i = 2'b00;
  logic       uart_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       data_vld_i = 1'b0;
  logic [7:0] cksum_o;
  logic       cksum_rdy_o, cksum_err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lin_cksum_unit i_lin_cksum_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pid_i(pid_i), .len_i(len_i),
    .classic_i(classic_i), .lin_cfg_i(lin_cfg_i), .uart_i(uart_i),
    .data_i(data_i), .data_vld_i(data_vld_i), .cksum_o(cksum_o),
    .cksum_rdy_o(cksum_rdy_o), .cksum_err_o(cksum_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int dbyte(input int seed, input int i);
    if (seed < 0) return 255;
    return (seed * 37 + i * 91 + 13) % 256;
  endfunction

  // integer total first, carries folded back afterwards
  function automatic int ref_sum(input int pid, input bit cls, input int n, input int seed);
    int t = cls ? 0 : pid;
    for (int i = 0; i < n; i++) t += dbyte(seed, i);
    while (t > 255) t = (t % 256) + (t / 256);
    return t;
  endfunction

  task automatic open_frame(input int pid, input int len, input bit cls,
                            input int cfg, input bit uart);
    start_i = 1'b1; pid_i = 8'(pid); len_i = 4'(len);
    classic_i = cls; lin_cfg_i = 2'(cfg); uart_i = uart;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input int b);
    data_i = 8'(b); data_vld_i = 1'b1;
    @(negedge clk);
    data_vld_i = 1'b0;
  endtask

  task automatic frame(input int pid, input int len, input bit cls, input int cfg,
                       input bit uart, input int seed, input bit corrupt);
    int n, s, ck;
    bit supp;
    string tag;
    n = (len == 0) ? 1 : (len > 8 ? 8 : len);
    supp = uart || (cfg == 1);
    tag = uart ? "R3" : (cfg == 1 ? "R4" : (cls ? "R2" : "R1"));
    open_frame(pid, len, cls, cfg, uart);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) send(dbyte(seed, i));
      else begin
        send(dbyte(seed, i));
        chk(cksum_rdy_o == 1'b0, "R7", "rdy early", cksum_rdy_o, 0);
      end
    end
    s = ref_sum(pid, cls, n, seed);
    ck = supp ? 0 : (255 - s);
    chk(cksum_o == 8'(ck), tag, "cksum_o (R5)", cksum_o, ck);
    chk(cksum_rdy_o == !supp, "R7", "rdy after last byte", cksum_rdy_o, !supp);
    send(corrupt ? ((255 - s) ^ 1) : (255 - s));
    chk(cksum_err_o == (!supp && corrupt), supp ? tag : "R6", "err pulse",
        cksum_err_o, !supp && corrupt);
    @(negedge clk);
    chk(cksum_err_o == 1'b0, "R6", "err one cycle", cksum_err_o, 0);
    send(8'h5A);
    chk(cksum_o == 8'(ck) && !cksum_err_o, "R9", "byte after frame", cksum_o, ck);
    chk(cksum_rdy_o == 1'b0, "R9", "rdy after frame", cksum_rdy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s_a, s_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cksum_o == 8'h00, "R10", "reset cksum", cksum_o, 0);
    chk(!cksum_rdy_o && !cksum_err_o, "R10", "reset flags", cksum_rdy_o, 0);
    // R9: bytes before any start
    send(8'h00); send(8'h37);
    chk(!cksum_err_o && !cksum_rdy_o && cksum_o == 8'h00, "R9", "pre-start bytes",
        cksum_o, 0);

    // sweep
    for (int len = 0; len < 16; len++)
      for (int cls = 0; cls < 2; cls++)
        for (int cfg = 0; cfg < 4; cfg++)
          for (int u = 0; u < 2; u++)
            frame((len * 29 + cfg * 71 + u * 5 + cls) % 256, len, cls[0], cfg, u[0],
                  len * 8 + cfg * 2 + u, (len + cfg + cls) % 2 == 1);

    // R5: heavy carry chains
    frame(255, 8, 1'b0, 0, 1'b0, -1, 1'b0);
    frame(255, 8, 1'b1, 2, 1'b0, -1, 1'b1);
    frame(0, 3, 1'b0, 3, 1'b0, -1, 1'b1);

    // R8: start coincides with a checksum byte (wrong, then correct)
    for (int good = 0; good < 2; good++) begin
      open_frame(8'hC4, 2, 1'b0, 0, 1'b0);
      send(dbyte(5, 0)); send(dbyte(5, 1));
      s_a = ref_sum(8'hC4, 1'b0, 2, 5);
      start_i = 1'b1; pid_i = 8'h21; len_i = 4'd3; classic_i = 1'b1;
      data_i = 8'(good ? (255 - s_a) : (255 - s_a) ^ 8'h10); data_vld_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; data_vld_i = 1'b0;
      chk(cksum_err_o == !good, "R8", "overlap judged on old frame", cksum_err_o, !good);
      for (int i = 0; i < 3; i++) send(dbyte(9, i));
      s_b = ref_sum(8'h21, 1'b1, 3, 9);
      chk(cksum_o == 8'(255 - s_b), "R8", "new frame excludes overlap byte",
          cksum_o, 255 - s_b);
      send(255 - s_b);
      chk(cksum_err_o == 1'b0, "R8", "new frame check", cksum_err_o, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule